// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a configuration slave for a small on-chip register array. An external controller drives it with a serial clock, an active-low select and one shared data line. Each transaction starts with a 16-bit command word holding a direction flag, a two-bit length code and a 13-bit starting address. One or more 8-bit data words follow. On a write, each word goes into the array. On a read, the block takes over the data line straight after the command word and shifts the addressed register back out.

The serial pins are oversampled by the block clock. The pads are outside the block: the data line appears as a separate input, output and output-enable. Register 0, bit 0 selects the bit order. It is cleared at reset, which gives most-significant-bit-first order. The order also sets the direction of the address step between words. A frame can be suspended by raising select at a word boundary and resumed by lowering it again. A streaming length keeps the frame open until select rises at a word boundary.

Top module: `spi3_reg_slave`

## Requirements
- R1: After reset every register reads 0x00, the output enable is low and bit order is most-significant-bit first.
- R2: A frame starts on the first sampled serial-clock rising edge while select is low. Its first 16 bits form the command word. In most-significant-first order these are bit 15 = direction (1 = read), bits 14:13 = length code and bits 12:0 = start address.
- R3: Length code 0, 1 or 2 moves 1, 2 or 3 data words. Once the last word is moved, further clock edges are ignored until select rises.
- R4: A written word is stored only when its eighth bit arrives. Raising select partway through a data word or partway through the command word abandons the frame and changes no register.
- R5: On a read, the output enable rises after the 16th command bit's rising edge. The current data bit is presented until the next rising edge. The enable stays high only during the data words of that read frame.
- R6: In a counted frame, raising select at a word boundary suspends the frame. When select falls again, transfer continues with the next data word and no new command word.
- R7: Length code 3 streams data words with no count limit. Raising select at a word boundary ends the frame.
- R8: Writing 1 to register 0 bit 0 switches both command and data to least-significant-bit-first order. The new order applies from the next data word.
- R9: After each data word the address steps down by one in most-significant-first order and up by one in least-significant-first order, wrapping modulo 8192.
- R10: Addresses at or above the register count discard writes and read as 0x00.
- R11: While select is high, serial-clock edges have no effect and the output enable is low.
- R12: The data output is 0 whenever the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Data the block places on the line during readback |
| sdio_oe | output | 1 | High while the block drives the data line |

## Verification
The bench builds the block with 16 registers, register 0 as the bit-order register and bit 0 as the order bit. With these values, the out-of-range addresses 16 and 100 and the wrap from 8191 to 0 can be reached within short frames. A behavioural model tracks the line direction and every expected output bit on each clock. It is exercised through counted, suspended, aborted and streaming frames in both bit orders.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int CMD_BITS  = 16;
  localparam int ADDR_W    = 13;
  localparam int WORD_W    = 8;
  localparam int CNT_W     = $clog2(CMD_BITS);
  localparam int POS8_W    = $clog2(WORD_W);
  localparam int DIR_POS   = 15;
  localparam int LEN_HI    = 14;
  localparam int LEN_LO    = 13;
  localparam logic [1:0] LEN_STREAM = 2'b11;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_CMD,
    FR_DATA,
    FR_DONE
  } fr_state_e;
endpackage

// File: rtl/spi3_rst_sync.sv
module spi3_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/spi3_edge.sv
module spi3_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic rise
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  // a rising edge only counts while the frame is selected
  assign rise = sclk & ~sclk_q & ~cs_n;
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdio_in,
  input  logic              rise,
  input  logic              lsb_first,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              sdio_oe,
  output logic              sdio_out
);
  fr_state_e              st_q, st_d;
  logic [CNT_W-1:0]       bit_q, bit_d;
  logic [CMD_BITS-1:0]    cmd_q, cmd_d, cmd_nx;
  logic                   rd_q, rd_d;
  logic [1:0]             len_q, len_d;
  logic [1:0]             bc_q, bc_d;
  logic [ADDR_W-1:0]      addr_q, addr_d;
  logic [WORD_W-1:0]      wb_q, wb_d, wb_nx;
  logic [CNT_W-1:0]       pos16;
  logic [POS8_W-1:0]      pos8;
  logic                   last_word;

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    cmd_d   = cmd_q;
    rd_d    = rd_q;
    len_d   = len_q;
    bc_d    = bc_q;
    addr_d  = addr_q;
    wb_d    = wb_q;
    wr_en   = 1'b0;

    pos16   = lsb_first ? bit_q : CNT_W'(CMD_BITS - 1) - bit_q;
    pos8    = lsb_first ? bit_q[POS8_W-1:0] : POS8_W'(WORD_W - 1) - bit_q[POS8_W-1:0];
    cmd_nx  = cmd_q;
    cmd_nx[pos16] = sdio_in;
    wb_nx   = wb_q;
    wb_nx[pos8] = sdio_in;
    wr_data = wb_nx;
    last_word = (len_q != LEN_STREAM) && (bc_q == len_q);

    unique case (st_q)
      FR_IDLE: begin
        if (rise) begin
          cmd_d = cmd_nx;
          bit_d = CNT_W'(1);
          st_d  = FR_CMD;
        end
      end
      FR_CMD: begin
        if (cs_n) begin
          st_d  = FR_IDLE;
          bit_d = '0;
        end else if (rise) begin
          cmd_d = cmd_nx;
          if (bit_q == CNT_W'(CMD_BITS - 1)) begin
            st_d   = FR_DATA;
            bit_d  = '0;
            rd_d   = cmd_nx[DIR_POS];
            len_d  = cmd_nx[LEN_HI:LEN_LO];
            addr_d = cmd_nx[ADDR_W-1:0];
            bc_d   = 2'd0;
          end else begin
            bit_d = bit_q + CNT_W'(1);
          end
        end
      end
      FR_DATA: begin
        if (cs_n) begin
          // mid-word or streaming boundary ends the frame; else it is a stall
          if ((bit_q != '0) || (len_q == LEN_STREAM)) begin
            st_d  = FR_IDLE;
            bit_d = '0;
          end
        end else if (rise) begin
          wb_d = wb_nx;
          if (bit_q == CNT_W'(WORD_W - 1)) begin
            bit_d  = '0;
            wr_en  = ~rd_q;
            addr_d = lsb_first ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);
            if (last_word) st_d = FR_DONE;
            else           bc_d = bc_q + 2'd1;
          end else begin
            bit_d = bit_q + CNT_W'(1);
          end
        end
      end
      FR_DONE: begin
        if (cs_n) begin
          st_d  = FR_IDLE;
          bit_d = '0;
        end
      end
      default: begin
        st_d  = FR_IDLE;
        bit_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      bit_q  <= '0;
      cmd_q  <= '0;
      rd_q   <= 1'b0;
      len_q  <= 2'd0;
      bc_q   <= 2'd0;
      addr_q <= '0;
      wb_q   <= '0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      if (rise) begin
        cmd_q <= cmd_d;
        wb_q  <= wb_d;
      end
      rd_q   <= rd_d;
      len_q  <= len_d;
      bc_q   <= bc_d;
      addr_q <= addr_d;
    end
  end

  assign addr     = addr_q;
  assign sdio_oe  = (st_q == FR_DATA) && rd_q && !cs_n;
  assign sdio_out = sdio_oe & rd_data[pos8];
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile
  import spi3_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int CFG_ADDR = 0,
  parameter int LSB_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              lsb_first
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word [NUM_REGS];

  assign hit = addr < LIMIT;
  assign idx = addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              en;
    logic [WORD_W-1:0] val_q;
    assign en = wr_en && hit && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (en) val_q <= wr_data;
    end
    assign word[g] = val_q;
  end

  assign rd_data   = hit ? word[idx] : '0;
  assign lsb_first = word[CFG_ADDR][LSB_BIT];
endmodule

// File: rtl/spi3_reg_slave.sv
module spi3_reg_slave
  import spi3_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int CFG_ADDR = 0,
  parameter int LSB_BIT  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe
);
  logic              rst_i_n;
  logic              rise;
  logic              lsb_first;
  logic              wr_en;
  logic [ADDR_W-1:0] reg_addr;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_data;

  spi3_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  spi3_edge i_edge (
    .clk(clk), .rst_n(rst_i_n), .sclk(sclk), .cs_n(cs_n), .rise(rise)
  );

  spi3_frame i_frame (
    .clk(clk), .rst_n(rst_i_n), .cs_n(cs_n), .sdio_in(sdio_in), .rise(rise),
    .lsb_first(lsb_first), .rd_data(rd_data), .addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .sdio_oe(sdio_oe), .sdio_out(sdio_out)
  );

  spi3_regfile #(.NUM_REGS(NUM_REGS), .CFG_ADDR(CFG_ADDR), .LSB_BIT(LSB_BIT)) i_regs (
    .clk(clk), .rst_n(rst_i_n), .addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .lsb_first(lsb_first)
  );
endmodule

// File: rtl/spi3_reg_slave_chk.sv
module spi3_reg_slave_chk #(
  parameter int CFG_ADDR = 0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk,
  input logic        cs_n,
  input logic        sdio_oe,
  input logic        sdio_out,
  input logic        wr_en,
  input logic [12:0] reg_addr,
  input logic        lsb_first
);
  // R11: the line is never driven while deselected
  p_oe_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !cs_n);

  // R12: idle output level
  p_quiet_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sdio_oe |-> !sdio_out);

  // R4: stores happen only on a selected serial-clock high phase
  p_write_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sclk && !cs_n));

  // R8: bit order changes only through a store to the order register
  p_order_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_addr == 13'(CFG_ADDR)) |=> $stable(lsb_first));

  // R5: the line turns around after a clock edge or on resume from a stall
  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> (($past(sclk) && !$past(sclk, 2)) || $fell(cs_n)));
endmodule

bind spi3_reg_slave spi3_reg_slave_chk #(.CFG_ADDR(CFG_ADDR)) i_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_oe(sdio_oe),
  .sdio_out(sdio_out), .wr_en(wr_en), .reg_addr(reg_addr), .lsb_first(lsb_first)
);

// File: tb/test_spi3_reg_slave.sv
module test_spi3_reg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe;
  int   errs = 0;
  int   checks = 0;

  always #4 clk = ~clk;

  spi3_reg_slave #(.NUM_REGS(16), .CFG_ADDR(0), .LSB_BIT(0)) i_spi3_reg_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  mmem [16];
  logic [15:0] mcmd;
  logic [7:0]  mwb;
  int ms, mbit, mrd, mlen, mbc, maddr;
  bit mprev;

  function automatic bit mlsb();
    return mmem[0][0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mmem[i]) mmem[i] = 8'h00;
      ms = 0; mbit = 0; mrd = 0; mlen = 0; mbc = 0; maddr = 0; mprev = 0;
      mcmd = '0; mwb = '0;
    end else begin
      bit r;
      r = sclk && !mprev && !cs_n;
      mprev = sclk;
      if (ms == 1 && cs_n) begin ms = 0; mbit = 0; end
      else if (ms == 2 && cs_n && (mbit != 0 || mlen == 3)) begin ms = 0; mbit = 0; end
      else if (ms == 3 && cs_n) begin ms = 0; mbit = 0; end
      else if (r && ms <= 1) begin
        mcmd[mlsb() ? mbit : 15 - mbit] = sdio_in;
        mbit++;
        ms = 1;
        if (mbit == 16) begin
          ms = 2; mbit = 0; mrd = mcmd[15]; mlen = mcmd[14:13];
          maddr = mcmd[12:0]; mbc = 0;
        end
      end else if (r && ms == 2) begin
        mwb[mlsb() ? mbit : 7 - mbit] = sdio_in;
        mbit++;
        if (mbit == 8) begin
          int nxt;
          mbit = 0;
          nxt = (maddr + (mlsb() ? 1 : -1)) & 8191;
          if (!mrd && maddr < 16) mmem[maddr] = mwb;
          maddr = nxt;
          if (mlen != 3 && mbc == mlen) ms = 3;
          else mbc++;
        end
      end
    end
  end

  always @(posedge clk) begin
    logic eoe, eout;
    #2;
    eoe  = (ms == 2) && (mrd != 0) && !cs_n;
    eout = 1'b0;
    if (eoe && maddr < 16) eout = mmem[maddr][mlsb() ? mbit : 7 - mbit];
    chk("R5 R11 output enable", 32'(sdio_oe), 32'(eoe));
    chk("R12 data output", 32'(sdio_out), 32'(eout));
  end

  // ---------------- controller tasks ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sclk = 1'b0; sdio_in = b;
    tick(2);
    r = sdio_out;
    sclk = 1'b1;
    tick(2);
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0; tick(2);
  endtask

  task automatic cs_high();
    @(negedge clk); cs_n = 1'b1; tick(4);
  endtask

  task automatic send_bits(input logic [15:0] w, input int n, input bit lsb, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      int p;
      logic rb;
      p = lsb ? i : n - 1 - i;
      bit_io(w[p], rb);
      got[p] = rb;
    end
  endtask

  task automatic cmd(input bit rd, input logic [1:0] len, input logic [12:0] a, input bit lsb);
    logic [15:0] g;
    send_bits({rd, len, a}, 16, lsb, g);
  endtask

  task automatic wword(input logic [7:0] d, input bit lsb);
    logic [15:0] g;
    send_bits({8'h00, d}, 8, lsb, g);
  endtask

  task automatic rword(input bit lsb, output logic [7:0] d);
    logic [15:0] g;
    send_bits(16'h0000, 8, lsb, g);
    d = g[7:0];
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d, input bit lsb);
    cs_low(); cmd(1'b0, 2'b00, a, lsb); wword(d, lsb); cs_high();
  endtask

  task automatic rd1(input logic [12:0] a, input bit lsb, output logic [7:0] d);
    cs_low(); cmd(1'b1, 2'b00, a, lsb); rword(lsb, d); cs_high();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    logic [15:0] g;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk("R1 enable low after reset", 32'(sdio_oe), 32'h0);
    rd1(13'd5, 0, d);  chk("R1 reg5 reset value", 32'(d), 32'h00);
    rd1(13'd0, 0, d);  chk("R1 order reg reset value", 32'(d), 32'h00);

    wr1(13'd3, 8'hA5, 0);
    rd1(13'd3, 0, d);  chk("R2 single write/read", 32'(d), 32'hA5);

    cs_low(); cmd(1'b0, 2'b10, 13'd10, 0);
    wword(8'h11, 0); wword(8'h22, 0); wword(8'h33, 0); cs_high();
    rd1(13'd10, 0, d); chk("R3 three-word write first", 32'(d), 32'h11);
    rd1(13'd9, 0, d);  chk("R9 descending second", 32'(d), 32'h22);
    rd1(13'd8, 0, d);  chk("R9 descending third", 32'(d), 32'h33);
    cs_low(); cmd(1'b1, 2'b01, 13'd10, 0);
    rword(0, d); chk("R3 two-word read first", 32'(d), 32'h11);
    rword(0, d); chk("R3 two-word read second", 32'(d), 32'h22);
    cs_high();

    cs_low(); cmd(1'b0, 2'b00, 13'd4, 0);
    send_bits(16'h00FF, 4, 0, g); cs_high();
    rd1(13'd4, 0, d);  chk("R4 partial word dropped", 32'(d), 32'h00);
    cs_low(); send_bits({1'b0, 2'b00, 13'd6}, 8, 0, g); cs_high();
    rd1(13'd6, 0, d);  chk("R4 partial command dropped", 32'(d), 32'h00);
    wr1(13'd6, 8'h5A, 0);
    rd1(13'd6, 0, d);  chk("R4 next frame after abort", 32'(d), 32'h5A);

    cs_low(); cmd(1'b0, 2'b01, 13'd7, 0); wword(8'hC3, 0); cs_high();
    for (int i = 0; i < 16; i++) begin sdio_in = 1'b1; sclk = ~sclk; tick(2); end
    cs_low(); wword(8'h3C, 0); cs_high();
    rd1(13'd7, 0, d);  chk("R6 word before stall", 32'(d), 32'hC3);
    rd1(13'd6, 0, d);  chk("R6 R11 word after stall", 32'(d), 32'h3C);
    for (int i = 0; i < 20; i++) begin sdio_in = 1'b1; sclk = ~sclk; tick(2); end
    rd1(13'd5, 0, d);  chk("R11 clocks while deselected", 32'(d), 32'h00);

    cs_low(); cmd(1'b0, 2'b00, 13'd12, 0); wword(8'h77, 0); wword(8'h88, 0); cs_high();
    rd1(13'd12, 0, d); chk("R3 counted word stored", 32'(d), 32'h77);
    rd1(13'd11, 0, d); chk("R3 extra word ignored", 32'(d), 32'h00);

    cs_low(); cmd(1'b0, 2'b11, 13'd15, 0);
    wword(8'hF0, 0); wword(8'hF1, 0); wword(8'hF2, 0); wword(8'hF3, 0); cs_high();
    rd1(13'd12, 0, d); chk("R7 fourth streamed word", 32'(d), 32'hF3);
    cs_low(); cmd(1'b1, 2'b11, 13'd15, 0);
    rword(0, d); chk("R7 stream read 0", 32'(d), 32'hF0);
    rword(0, d); chk("R7 stream read 1", 32'(d), 32'hF1);
    rword(0, d); chk("R7 stream read 2", 32'(d), 32'hF2);
    cs_high();
    rd1(13'd15, 0, d); chk("R7 frame ended by select", 32'(d), 32'hF0);

    wr1(13'd100, 8'hEE, 0);
    rd1(13'd100, 0, d); chk("R10 high address reads zero", 32'(d), 32'h00);
    cs_low(); cmd(1'b0, 2'b01, 13'd16, 0); wword(8'hAA, 0); wword(8'hBB, 0); cs_high();
    rd1(13'd15, 0, d); chk("R10 R9 step from out of range", 32'(d), 32'hBB);

    wr1(13'd0, 8'h01, 0);
    rd1(13'd0, 1, d);  chk("R8 order register in lsb mode", 32'(d), 32'h01);
    rd1(13'd3, 1, d);  chk("R8 lsb-first readback", 32'(d), 32'hA5);
    cs_low(); cmd(1'b0, 2'b01, 13'd1, 1); wword(8'h12, 1); wword(8'h34, 1); cs_high();
    rd1(13'd1, 1, d);  chk("R9 ascending first", 32'(d), 32'h12);
    rd1(13'd2, 1, d);  chk("R9 ascending second", 32'(d), 32'h34);
    cs_low(); cmd(1'b1, 2'b01, 13'd8191, 1);
    rword(1, d); chk("R9 top address", 32'(d), 32'h00);
    rword(1, d); chk("R9 wrap to zero", 32'(d), 32'h01);
    cs_high();
    wr1(13'd0, 8'h00, 1);
    rd1(13'd3, 0, d);  chk("R8 back to msb-first", 32'(d), 32'hA5);

    tick(4);
    finish_run();
  end
endmodule